// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a bus-attached watchdog. Software writes a timeout, in input clock ticks, to a value register, then arms the timer by writing a fixed pair of key words to a control register. A 32-bit counter then counts down once per clock. Writing the same arming pair again while the timer runs services it: the counter reloads from the value register. A different key pair halts the timer. If software fails to service the timer in time, the counter reaches zero and the block raises a reset request for the system reset controller.

A control write counts only when it is part of an exact pair of key words with no other bus write between the two halves. A lone or corrupted write therefore cannot start, service or stop the watchdog. Reads return either the live remaining count or a small status word. Read data appears one cycle after the read strobe.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timer is stopped, the counter is 0, the reset request is low, and the stored timeout is 0xFFFFFFFE. An arming pair issued straight after reset therefore loads 0xFFFFFFFE.
- R2: A write to offset 0x0 stores the timeout clamped to the range 2..0xFFFFFFFE. 0 and 1 are stored as 2, 0xFFFFFFFF is stored as 0xFFFFFFFE, and values in range are stored unchanged.
- R3: Two control writes (offset 0x4) arm the timer: 0x0000FF00, then 0x000000FF. The edge that takes the second word loads the counter from the stored timeout and sets the running flag. The counter then drops by one on every later clock edge.
- R4: Repeating the arming pair while the timer runs reloads the counter from the stored timeout.
- R5: Two control writes stop the timer: 0x0000EE00, then 0x000000EE. This clears the running flag and the reset request, and the counter keeps its current value.
- R6: A pair is broken if any other bus write comes between its halves, whether to the value register, to an unmapped offset, or to the control register with a word that is not the expected second half. A second half written on its own does nothing.
- R7: A first-half word that arrives while the other pair's first half is pending discards the pending one and waits for the second half of the newer pair.
- R8: The reset request rises on the clock edge that brings a running counter to 0, which is the edge a timeout of T puts T edges after the load. The counter then holds at 0. The request stays high, and an arming pair has no effect, until a stop pair or a system reset.
- R9: A read strobe returns its data on `bus_rdata` one cycle later. Offset 0x0 gives the remaining count. Offset 0x4 gives the running flag in bit 0 and the expired flag in bit 1, with all other bits 0. Any other offset reads as 0.
- R10: Clock cycles with no bus write between the two halves of a pair do not break the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; the counter ticks on it |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 3 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| wdog_rst_req | output | 1 | Reset request, high while expired |

## Verification
Faults inside this block usually show up quickly at the bus. A counter that loads or decrements wrongly gives a wrong count on the first readback after arming. A wrong expiry edge moves `wdog_rst_req` by one or more cycles against a bench that counts edges from the load. A sequence detector stuck in the wrong phase either starts the timer or fails to start it, and the status word shows this on the next read. A lost or spurious expired flag appears both at the request pin and in bit 1 of the status word.

// File: rtl/kw_pkg.sv
package kw_pkg;

    // Phases of the two-write key detector
    typedef enum logic [1:0] {
        KW_IDLE      = 2'd0,
        KW_ARM_START = 2'd1,
        KW_ARM_STOP  = 2'd2
    } kw_phase_e;

    // Decoded command, one cycle wide
    typedef struct packed {
        logic start;
        logic stop;
    } kw_cmd_t;

    // Default key words
    localparam logic [31:0] KW_START_A = 32'h0000_FF00;
    localparam logic [31:0] KW_START_B = 32'h0000_00FF;
    localparam logic [31:0] KW_STOP_A  = 32'h0000_EE00;
    localparam logic [31:0] KW_STOP_B  = 32'h0000_00EE;

endpackage

// File: rtl/kw_seq_detect.sv
module kw_seq_detect
    import kw_pkg::*;
#(
    parameter int unsigned         DATA_W  = 32,
    parameter logic [DATA_W-1:0]   START_A = DATA_W'(KW_START_A),
    parameter logic [DATA_W-1:0]   START_B = DATA_W'(KW_START_B),
    parameter logic [DATA_W-1:0]   STOP_A  = DATA_W'(KW_STOP_A),
    parameter logic [DATA_W-1:0]   STOP_B  = DATA_W'(KW_STOP_B)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_wr,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output kw_cmd_t           cmd
);

    typedef struct packed {
        kw_phase_e phase;
    } seq_state_t;

    seq_state_t st_d, st_q;
    kw_cmd_t    cmd_d;

    always_comb begin
        st_d  = st_q;
        cmd_d = '0;
        // Only bus writes move the detector; idle cycles keep the phase
        if (any_wr) begin
            if (ctrl_wr && st_q.phase == KW_ARM_START && wdata == START_B) begin
                cmd_d.start = 1'b1;
                st_d.phase  = KW_IDLE;
            end else if (ctrl_wr && st_q.phase == KW_ARM_STOP && wdata == STOP_B) begin
                cmd_d.stop  = 1'b1;
                st_d.phase  = KW_IDLE;
            end else if (ctrl_wr && wdata == START_A) begin
                st_d.phase  = KW_ARM_START;
            end else if (ctrl_wr && wdata == STOP_A) begin
                st_d.phase  = KW_ARM_STOP;
            end else begin
                st_d.phase  = KW_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= KW_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd = cmd_d;

endmodule

// File: rtl/kw_value_reg.sv
module kw_value_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              val_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] timeout
);

    localparam logic [DATA_W-1:0] T_MIN = DATA_W'(2);
    localparam logic [DATA_W-1:0] T_MAX = ~DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] ticks;
    } val_state_t;

    val_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (val_wr) begin
            if (wdata < T_MIN) begin
                st_d.ticks = T_MIN;
            end else if (wdata > T_MAX) begin
                st_d.ticks = T_MAX;
            end else begin
                st_d.ticks = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ticks <= T_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign timeout = st_q.ticks;

endmodule

// File: rtl/kw_timer.sv
module kw_timer
    import kw_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  kw_cmd_t           cmd,
    input  logic [DATA_W-1:0] timeout,
    output logic [DATA_W-1:0] count,
    output logic              running,
    output logic              expired
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              run;
        logic              exp;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd.stop) begin
            // Halt: counter keeps its value, request drops
            st_d.run = 1'b0;
            st_d.exp = 1'b0;
        end else if (cmd.start && !st_q.exp) begin
            st_d.cnt = timeout;
            st_d.run = 1'b1;
        end else if (st_q.run && !st_q.exp) begin
            if (st_q.cnt <= ONE) begin
                st_d.cnt = '0;
                st_d.exp = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.run <= 1'b0;
            st_q.exp <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign running = st_q.run;
    assign expired = st_q.exp;

endmodule

// File: rtl/kw_readback.sv
module kw_readback #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned VALUE_OFS = 0,
    parameter int unsigned CTRL_OFS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] count,
    input  logic              running,
    input  logic              expired,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rb_state_t;

    rb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd) begin
            if (addr == ADDR_W'(VALUE_OFS)) begin
                st_d.data = count;
            end else if (addr == ADDR_W'(CTRL_OFS)) begin
                st_d.data = {{(DATA_W-2){1'b0}}, expired, running};
            end else begin
                st_d.data = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.data;

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kw_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned VALUE_OFS = 0,
    parameter int unsigned CTRL_OFS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdog_rst_req
);

    logic              ctrl_wr;
    logic              val_wr;
    kw_cmd_t           seq_cmd;
    logic [DATA_W-1:0] timeout;
    logic [DATA_W-1:0] count;
    logic              running;
    logic              expired;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
    assign val_wr  = bus_wr && (bus_addr == ADDR_W'(VALUE_OFS));

    kw_seq_detect #(.DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_wr  (bus_wr),
        .ctrl_wr (ctrl_wr),
        .wdata   (bus_wdata),
        .cmd     (seq_cmd)
    );

    kw_value_reg #(.DATA_W(DATA_W)) u_val (
        .clk     (clk),
        .rst_n   (rst_n),
        .val_wr  (val_wr),
        .wdata   (bus_wdata),
        .timeout (timeout)
    );

    kw_timer #(.DATA_W(DATA_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (seq_cmd),
        .timeout (timeout),
        .count   (count),
        .running (running),
        .expired (expired)
    );

    kw_readback #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .VALUE_OFS (VALUE_OFS),
        .CTRL_OFS  (CTRL_OFS)
    ) u_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .count   (count),
        .running (running),
        .expired (expired),
        .rdata   (bus_rdata)
    );

    assign wdog_rst_req = expired;

endmodule

// File: rtl/kw_checker.sv
module kw_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_evt,
    input logic              stop_evt,
    input logic [DATA_W-1:0] timeout,
    input logic [DATA_W-1:0] count,
    input logic              running,
    input logic              req
);

    localparam logic [DATA_W-1:0] T_MAX = ~DATA_W'(1);

    // R2: stored timeout always within the legal range
    a_r2_timeout_range: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout >= DATA_W'(2)) && (timeout <= T_MAX));

    // R3: start event loads the stored timeout and sets running
    a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt && !req) |=> (running && count == $past(timeout)));

    // R3: free running counter drops by one per edge
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !req && !start_evt && !stop_evt && count > DATA_W'(1))
        |=> (count == $past(count) - DATA_W'(1)));

    // R5: stop event clears running and the request
    a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!running && !req));

    // R6: detector never issues both commands together
    a_r6_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_evt, stop_evt}));

    // R8: request is sticky until stop
    a_r8_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !stop_evt) |=> req);

    // R8: counter sits at zero while the request is high
    a_r8_zero_when_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (count == '0));

endmodule

bind keyed_watchdog kw_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (seq_cmd.start),
    .stop_evt  (seq_cmd.stop),
    .timeout   (timeout),
    .count     (count),
    .running   (running),
    .req       (wdog_rst_req)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdog_rst_req;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    keyed_watchdog u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .wdog_rst_req (wdog_rst_req)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge; each access uses one rising edge
    task automatic wr(logic [2:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_pair();
        wr(3'd4, 32'h0000_FF00);
        wr(3'd4, 32'h0000_00FF);
    endtask

    task automatic stop_pair();
        wr(3'd4, 32'h0000_EE00);
        wr(3'd4, 32'h0000_00EE);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 req after reset", {31'b0, wdog_rst_req}, 32'd0);
        rd(3'd4, v); chk("R1 status after reset", v, 32'd0);
        rd(3'd0, v); chk("R1 count after reset", v, 32'd0);
        start_pair();
        rd(3'd0, v); chk("R1 default timeout", v, 32'hFFFF_FFFE);
        stop_pair();
    endtask

    task automatic t_clamp();
        logic [31:0] v;
        wr(3'd0, 32'd0); start_pair();
        rd(3'd0, v); chk("R2 clamp 0 to 2", v, 32'd2);
        chk("R2 min not expired yet", {31'b0, wdog_rst_req}, 32'd0);
        idle(1);
        chk("R2 min expires after 2 ticks", {31'b0, wdog_rst_req}, 32'd1);
        stop_pair();
        wr(3'd0, 32'd1); start_pair();
        rd(3'd0, v); chk("R2 clamp 1 to 2", v, 32'd2);
        stop_pair();
        wr(3'd0, 32'hFFFF_FFFF); start_pair();
        rd(3'd0, v); chk("R2 clamp top", v, 32'hFFFF_FFFE);
        stop_pair();
        wr(3'd0, 32'd3); start_pair();
        rd(3'd0, v); chk("R2 in range kept", v, 32'd3);
        stop_pair();
    endtask

    task automatic t_expire();
        logic [31:0] v;
        wr(3'd0, 32'd10); start_pair();
        rd(3'd0, v); chk("R3 loaded", v, 32'd10);
        rd(3'd0, v); chk("R3 decrement", v, 32'd9);
        rd(3'd4, v); chk("R9 running status", v, 32'h1);
        idle(5);
        chk("R8 no early req", {31'b0, wdog_rst_req}, 32'd0);
        rd(3'd0, v); chk("R3 count before expiry", v, 32'd2);
        chk("R8 req low one edge early", {31'b0, wdog_rst_req}, 32'd0);
        idle(1);
        chk("R8 req on T-th edge", {31'b0, wdog_rst_req}, 32'd1);
        idle(3);
        rd(3'd0, v); chk("R8 count holds zero", v, 32'd0);
        rd(3'd4, v); chk("R9 expired status", v, 32'h3);
        start_pair();
        rd(3'd0, v); chk("R8 start ignored when expired", v, 32'd0);
        chk("R8 req sticky", {31'b0, wdog_rst_req}, 32'd1);
        stop_pair();
        chk("R5 stop clears req", {31'b0, wdog_rst_req}, 32'd0);
        rd(3'd4, v); chk("R5 status after stop", v, 32'd0);
    endtask

    task automatic t_service();
        logic [31:0] v;
        wr(3'd0, 32'd20); start_pair();
        idle(10);
        start_pair();
        rd(3'd0, v); chk("R4 reload", v, 32'd20);
        idle(15);
        rd(3'd0, v); chk("R4 counting after reload", v, 32'd4);
        start_pair();
        rd(3'd0, v); chk("R4 second reload", v, 32'd20);
        chk("R4 no req", {31'b0, wdog_rst_req}, 32'd0);
        stop_pair();
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(3'd0, 32'd50); start_pair();
        idle(5);
        stop_pair();
        rd(3'd0, v); chk("R5 count frozen", v, 32'd44);
        idle(60);
        rd(3'd0, v); chk("R5 count still frozen", v, 32'd44);
        chk("R5 no req while stopped", {31'b0, wdog_rst_req}, 32'd0);
    endtask

    task automatic t_broken();
        logic [31:0] v;
        wr(3'd4, 32'h0000_FF00); wr(3'd0, 32'd5); wr(3'd4, 32'h0000_00FF);
        rd(3'd4, v); chk("R6 value write breaks start", v, 32'd0);
        rd(3'd0, v); chk("R6 count untouched", v, 32'd44);
        wr(3'd4, 32'h0000_FF00); wr(3'd4, 32'h0000_1234); wr(3'd4, 32'h0000_00FF);
        rd(3'd4, v); chk("R6 wrong data breaks start", v, 32'd0);
        wr(3'd4, 32'h0000_00FF);
        rd(3'd4, v); chk("R6 lone second half", v, 32'd0);
        wr(3'd0, 32'd100); start_pair();
        wr(3'd4, 32'h0000_EE00); wr(3'd4, 32'h0000_00FF); wr(3'd4, 32'h0000_00EE);
        rd(3'd0, v); chk("R6 count runs on", v, 32'd97);
        rd(3'd4, v); chk("R6 broken stop ignored", v, 32'd1);
        wr(3'd4, 32'h0000_EE00); wr(3'd2, 32'h0000_00EE); wr(3'd4, 32'h0000_00EE);
        rd(3'd4, v); chk("R6 unmapped write breaks stop", v, 32'd1);
        stop_pair();
    endtask

    task automatic t_rearm();
        logic [31:0] v;
        wr(3'd4, 32'h0000_EE00); wr(3'd4, 32'h0000_FF00); wr(3'd4, 32'h0000_00FF);
        rd(3'd4, v); chk("R7 rearm to start", v, 32'd1);
        wr(3'd4, 32'h0000_FF00); wr(3'd4, 32'h0000_EE00); wr(3'd4, 32'h0000_00EE);
        rd(3'd4, v); chk("R7 rearm to stop", v, 32'd0);
    endtask

    task automatic t_gap();
        logic [31:0] v;
        wr(3'd0, 32'd30);
        wr(3'd4, 32'h0000_FF00);
        idle(4);
        wr(3'd4, 32'h0000_00FF);
        rd(3'd0, v); chk("R10 gap keeps pair", v, 32'd30);
        stop_pair();
    endtask

    task automatic t_readmap();
        logic [31:0] v;
        rd(3'd2, v); chk("R9 unmapped read 2", v, 32'd0);
        rd(3'd6, v); chk("R9 unmapped read 6", v, 32'd0);
        idle(3);
        chk("R9 rdata holds without strobe", bus_rdata, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clamp();
        t_expire();
        t_service();
        t_stop();
        t_broken();
        t_rearm();
        t_gap();
        t_readmap();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (R3) actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule